// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block performs the register updates that a simple 32-bit RISC core needs when it enters an exception or interrupt handler. Each cycle it looks at one synchronous exception request (a valid strobe plus an exception number) and at two asynchronous interrupt lines, one external and one from the tick timer. It picks at most one source. If it accepts a request, it produces every entry result in a single registered step: the handler address, the saved return PC, the saved status word, the new status word, a cleared delay-slot flag, a one-cycle TLB-flush pulse and a sticky flag that says translation is now off.

The saved return PC depends on the context of the faulting instruction. An exception taken on an instruction in a branch delay slot points back at the branch. A system call points past the calling instruction. When both apply, the two adjustments cancel. If a synchronous request carries a number that has no handler slot, the block raises an error pulse, keeps the PC and performs no entry.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and on the first cycles after it, every output is zero.
- R2: On an accepted entry, `epc_o` equals `pc_i` minus 4 if `dslot_i` was set, plus 4 if the request was a synchronous code 12 (system call). Both adjustments apply together.
- R3: On an accepted entry, `esr_o` equals `sr_i` as presented, before any bit of it is modified.
- R4: On an accepted entry, `sr_o` is `sr_i` with bit 0 (supervisor) set, bits 1 (tick enable), 2 (external interrupt enable), 3 (data translation enable) and 4 (instruction translation enable) cleared, and bit 5 (delay-slot exception) set when `dslot_i` was set. All other bits are kept.
- R5: On an accepted entry, `dslot_o` is 0. On any other cycle, `sr_o` and `dslot_o` repeat `sr_i` and `dslot_i` one cycle later.
- R6: On an accepted entry, `new_pc_o` equals the exception number shifted left by 8, and `exc_code_o` gives that number.
- R7: A synchronous request with code 0 or code 14 to 31 pulses `unhandled_o` for one cycle and sets `new_pc_o` to `pc_i`. It gives no entry, and `epc_o`, `esr_o` and `exc_code_o` keep their values.
- R8: The external interrupt (number 8) is taken only if `sr_i` bit 2 is set. The tick interrupt (number 5) is taken only if `sr_i` bit 1 is set. A masked request gives no entry and changes no saved value.
- R9: When both interrupts are pending and enabled, the tick interrupt (number 5) is taken.
- R10: A valid synchronous request takes precedence over any interrupt in the same cycle, including one whose code is out of range.
- R11: Every accepted entry asserts `entry_valid_o` and `tlb_flush_o` together for exactly one cycle and sets `phys_mode_o`. The two pulses are low in every cycle without an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 32 | Current status word |
| dslot_i | input | 1 | Current instruction sits in a delay slot |
| sync_valid_i | input | 1 | Synchronous exception request strobe |
| sync_code_i | input | 5 | Synchronous exception number |
| ext_irq_i | input | 1 | External interrupt pending |
| tick_irq_i | input | 1 | Tick timer interrupt pending |
| entry_valid_o | output | 1 | One-cycle strobe per accepted entry |
| exc_code_o | output | 5 | Number of the last accepted exception |
| new_pc_o | output | 32 | Handler address (or unchanged PC on error) |
| epc_o | output | 32 | Saved return PC |
| esr_o | output | 32 | Saved status word |
| sr_o | output | 32 | Updated status word |
| dslot_o | output | 1 | Delay-slot flag after update |
| tlb_flush_o | output | 1 | TLB flush request pulse |
| phys_mode_o | output | 1 | Translation switched to untranslated mode |
| unhandled_o | output | 1 | Out-of-range exception number pulse |

## Verification
Several properties are checked on every cycle:
- the status word is saved unmodified, and the new status word has the required set and cleared bits;
- the delay-slot flag is cleared on entry;
- the handler address matches the reported number;
- masked interrupts leave the saved PC alone;
- tick wins over external;
- a synchronous request is never displaced by an interrupt;
- an error never coincides with an entry.

The exact saved-PC arithmetic is shown only by the bench's scenarios: the plain, delay-slot, system-call and combined cases, swept over every synchronous number. The same applies to the full sixteen-way interrupt mask and pending matrix, with and without a competing synchronous request, and to the hold behaviour across idle cycles.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    // Status word bit positions
    localparam int unsigned SRB_SUPER   = 0;
    localparam int unsigned SRB_TICK_EN = 1;
    localparam int unsigned SRB_EXT_EN  = 2;
    localparam int unsigned SRB_DXLAT   = 3;
    localparam int unsigned SRB_IXLAT   = 4;
    localparam int unsigned SRB_DSEXC   = 5;

    // Source picked by the arbiter
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SYNC = 2'd1,
        SRC_TICK = 2'd2,
        SRC_EXT  = 2'd3
    } exc_src_e;

endpackage

// File: rtl/exc_req_arbiter.sv
module exc_req_arbiter
    import exc_entry_pkg::*;
#(
    parameter int unsigned CODE_W    = 5,
    parameter int unsigned NUM_EXC   = 14,
    parameter int unsigned TICK_CODE = 5,
    parameter int unsigned EXT_CODE  = 8
) (
    input  logic              sync_valid,
    input  logic [CODE_W-1:0] sync_code,
    input  logic              ext_irq,
    input  logic              tick_irq,
    input  logic              ext_en,
    input  logic              tick_en,
    output exc_src_e          src,
    output logic [CODE_W-1:0] code,
    output logic              bad_code
);
    localparam logic [CODE_W-1:0] TICK_C = CODE_W'(TICK_CODE);
    localparam logic [CODE_W-1:0] EXT_C  = CODE_W'(EXT_CODE);

    logic code_in_range;

    always_comb begin
        code_in_range = (sync_code != '0) && (32'(sync_code) < NUM_EXC);
    end

    always_comb begin
        src      = SRC_NONE;
        code     = '0;
        bad_code = 1'b0;
        if (sync_valid) begin
            if (code_in_range) begin
                src  = SRC_SYNC;
                code = sync_code;
            end else begin
                bad_code = 1'b1;
            end
        end else if (tick_irq && tick_en) begin
            src  = SRC_TICK;
            code = TICK_C;
        end else if (ext_irq && ext_en) begin
            src  = SRC_EXT;
            code = EXT_C;
        end
    end
endmodule

// File: rtl/exc_epc_adjust.sv
module exc_epc_adjust #(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc,
    input  logic            in_dslot,
    input  logic            is_syscall,
    output logic [XLEN-1:0] epc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] back_amt;
    logic [XLEN-1:0] fwd_amt;

    always_comb begin
        back_amt = in_dslot   ? STEP : '0;
        fwd_amt  = is_syscall ? STEP : '0;
        epc      = pc - back_amt + fwd_amt;
    end
endmodule

// File: rtl/exc_status_update.sv
module exc_status_update
    import exc_entry_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] sr_in,
    input  logic            in_dslot,
    output logic [XLEN-1:0] sr_out
);
    for (genvar b = 0; b < XLEN; b++) begin : g_bit
        if (b == SRB_SUPER) begin : g_set
            assign sr_out[b] = 1'b1;
        end else if (b == SRB_TICK_EN || b == SRB_EXT_EN ||
                     b == SRB_DXLAT   || b == SRB_IXLAT) begin : g_clr
            assign sr_out[b] = 1'b0;
        end else if (b == SRB_DSEXC) begin : g_ds
            assign sr_out[b] = in_dslot | sr_in[b];
        end else begin : g_keep
            assign sr_out[b] = sr_in[b];
        end
    end

    logic unused_bits;
    assign unused_bits = ^{sr_in[SRB_SUPER], sr_in[SRB_TICK_EN], sr_in[SRB_EXT_EN],
                           sr_in[SRB_DXLAT], sr_in[SRB_IXLAT]};
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int unsigned XLEN         = 32,
    parameter int unsigned CODE_W       = 5,
    parameter int unsigned NUM_EXC      = 14,
    parameter int unsigned VEC_SHIFT    = 8,
    parameter int unsigned SYSCALL_CODE = 12,
    parameter int unsigned TICK_CODE    = 5,
    parameter int unsigned EXT_CODE     = 8,
    parameter int unsigned INSN_BYTES   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic              dslot_i,
    input  logic              sync_valid_i,
    input  logic [CODE_W-1:0] sync_code_i,
    input  logic              ext_irq_i,
    input  logic              tick_irq_i,
    output logic              entry_valid_o,
    output logic [CODE_W-1:0] exc_code_o,
    output logic [XLEN-1:0]   new_pc_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   esr_o,
    output logic [XLEN-1:0]   sr_o,
    output logic              dslot_o,
    output logic              tlb_flush_o,
    output logic              phys_mode_o,
    output logic              unhandled_o
);
    localparam logic [CODE_W-1:0] SYSCALL_C = CODE_W'(SYSCALL_CODE);

    typedef struct packed {
        logic              valid;
        logic              flush;
        logic              err;
        logic              phys;
        logic              dslot;
        logic [CODE_W-1:0] code;
        logic [XLEN-1:0]   npc;
        logic [XLEN-1:0]   epc;
        logic [XLEN-1:0]   esr;
        logic [XLEN-1:0]   sr;
    } entry_st_t;

    entry_st_t st_d, st_q;

    exc_src_e          pick_src;
    logic [CODE_W-1:0] pick_code;
    logic              pick_bad;
    logic              is_syscall;
    logic [XLEN-1:0]   epc_calc;
    logic [XLEN-1:0]   sr_calc;
    logic [XLEN-1:0]   vec_addr;

    exc_req_arbiter #(
        .CODE_W    (CODE_W),
        .NUM_EXC   (NUM_EXC),
        .TICK_CODE (TICK_CODE),
        .EXT_CODE  (EXT_CODE)
    ) arb_i (
        .sync_valid (sync_valid_i),
        .sync_code  (sync_code_i),
        .ext_irq    (ext_irq_i),
        .tick_irq   (tick_irq_i),
        .ext_en     (sr_i[SRB_EXT_EN]),
        .tick_en    (sr_i[SRB_TICK_EN]),
        .src        (pick_src),
        .code       (pick_code),
        .bad_code   (pick_bad)
    );

    assign is_syscall = (pick_src == SRC_SYNC) && (pick_code == SYSCALL_C);

    exc_epc_adjust #(
        .XLEN       (XLEN),
        .INSN_BYTES (INSN_BYTES)
    ) epc_i (
        .pc         (pc_i),
        .in_dslot   (dslot_i),
        .is_syscall (is_syscall),
        .epc        (epc_calc)
    );

    exc_status_update #(
        .XLEN (XLEN)
    ) sru_i (
        .sr_in    (sr_i),
        .in_dslot (dslot_i),
        .sr_out   (sr_calc)
    );

    assign vec_addr = XLEN'(pick_code) << VEC_SHIFT;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.flush = 1'b0;
        st_d.err   = 1'b0;
        st_d.sr    = sr_i;
        st_d.dslot = dslot_i;
        if (pick_bad) begin
            st_d.err = 1'b1;
            st_d.npc = pc_i;
        end else if (pick_src != SRC_NONE) begin
            st_d.valid = 1'b1;
            st_d.flush = 1'b1;
            st_d.phys  = 1'b1;
            st_d.dslot = 1'b0;
            st_d.code  = pick_code;
            st_d.npc   = vec_addr;
            st_d.epc   = epc_calc;
            st_d.esr   = sr_i;
            st_d.sr    = sr_calc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign entry_valid_o = st_q.valid;
    assign exc_code_o    = st_q.code;
    assign new_pc_o      = st_q.npc;
    assign epc_o         = st_q.epc;
    assign esr_o         = st_q.esr;
    assign sr_o          = st_q.sr;
    assign dslot_o       = st_q.dslot;
    assign tlb_flush_o   = st_q.flush;
    assign phys_mode_o   = st_q.phys;
    assign unhandled_o   = st_q.err;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned CODE_W    = 5,
    parameter int unsigned VEC_SHIFT = 8,
    parameter int unsigned TICK_CODE = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   pc_i,
    input logic [XLEN-1:0]   sr_i,
    input logic              dslot_i,
    input logic              sync_valid_i,
    input logic [CODE_W-1:0] sync_code_i,
    input logic              ext_irq_i,
    input logic              tick_irq_i,
    input logic              entry_valid_o,
    input logic [CODE_W-1:0] exc_code_o,
    input logic [XLEN-1:0]   new_pc_o,
    input logic [XLEN-1:0]   epc_o,
    input logic [XLEN-1:0]   esr_o,
    input logic [XLEN-1:0]   sr_o,
    input logic              dslot_o,
    input logic              tlb_flush_o,
    input logic              phys_mode_o,
    input logic              unhandled_o
);
    AST_ESR_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid_o |-> esr_o == $past(sr_i)); // R3

    AST_SR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid_o |-> (sr_o[SRB_SUPER] && !sr_o[SRB_TICK_EN] && !sr_o[SRB_EXT_EN]
                           && !sr_o[SRB_DXLAT] && !sr_o[SRB_IXLAT])); // R4

    AST_DSLOT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid_o && $past(dslot_i)) |-> (!dslot_o && sr_o[SRB_DSEXC])); // R5

    AST_VEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid_o |-> new_pc_o == (XLEN'(exc_code_o) << VEC_SHIFT)); // R6

    AST_ERR_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        unhandled_o |-> (!entry_valid_o && new_pc_o == $past(pc_i))); // R7

    AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_valid_i && !(ext_irq_i && sr_i[SRB_EXT_EN]) && !(tick_irq_i && sr_i[SRB_TICK_EN]))
        |=> (!entry_valid_o && $stable(epc_o))); // R8

    AST_TICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_valid_i && tick_irq_i && sr_i[SRB_TICK_EN])
        |=> (entry_valid_o && exc_code_o == CODE_W'(TICK_CODE))); // R9

    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        sync_valid_i |=> (unhandled_o || exc_code_o == $past(sync_code_i))); // R10

    AST_FLUSH_PHYS: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid_o |-> (tlb_flush_o && phys_mode_o)); // R11
endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .XLEN      (XLEN),
    .CODE_W    (CODE_W),
    .VEC_SHIFT (VEC_SHIFT),
    .TICK_CODE (TICK_CODE)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pc_i          (pc_i),
    .sr_i          (sr_i),
    .dslot_i       (dslot_i),
    .sync_valid_i  (sync_valid_i),
    .sync_code_i   (sync_code_i),
    .ext_irq_i     (ext_irq_i),
    .tick_irq_i    (tick_irq_i),
    .entry_valid_o (entry_valid_o),
    .exc_code_o    (exc_code_o),
    .new_pc_o      (new_pc_o),
    .epc_o         (epc_o),
    .esr_o         (esr_o),
    .sr_o          (sr_o),
    .dslot_o       (dslot_o),
    .tlb_flush_o   (tlb_flush_o),
    .phys_mode_o   (phys_mode_o),
    .unhandled_o   (unhandled_o)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic [31:0] sr_i = '0;
    logic        dslot_i = 1'b0;
    logic        sync_valid_i = 1'b0;
    logic [4:0]  sync_code_i = '0;
    logic        ext_irq_i = 1'b0;
    logic        tick_irq_i = 1'b0;
    logic        entry_valid_o;
    logic [4:0]  exc_code_o;
    logic [31:0] new_pc_o, epc_o, esr_o, sr_o;
    logic        dslot_o, tlb_flush_o, phys_mode_o, unhandled_o;

    int checks = 0;
    int errors = 0;

    // expected held state
    logic [4:0]  m_code = '0;
    logic [31:0] m_npc = '0, m_epc = '0, m_esr = '0;
    logic        m_phys = 1'b0;

    always #4 clk = ~clk;

    exc_entry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .sr_i(sr_i), .dslot_i(dslot_i),
        .sync_valid_i(sync_valid_i), .sync_code_i(sync_code_i),
        .ext_irq_i(ext_irq_i), .tick_irq_i(tick_irq_i),
        .entry_valid_o(entry_valid_o), .exc_code_o(exc_code_o), .new_pc_o(new_pc_o),
        .epc_o(epc_o), .esr_o(esr_o), .sr_o(sr_o), .dslot_o(dslot_o),
        .tlb_flush_o(tlb_flush_o), .phys_mode_o(phys_mode_o), .unhandled_o(unhandled_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive one request at a negedge, then compare at the next negedge.
    task automatic step(input logic [31:0] pc, input logic [31:0] sr, input logic ds,
                        input logic sv, input logic [4:0] code,
                        input logic ext, input logic tick);
        logic        taken, err;
        logic [4:0]  c;
        logic [31:0] e_sr;
        logic        e_ds;
        pc_i = pc; sr_i = sr; dslot_i = ds; sync_valid_i = sv; sync_code_i = code;
        ext_irq_i = ext; tick_irq_i = tick;
        taken = 1'b0; err = 1'b0; c = '0;
        if (sv) begin
            if (code != 0 && code < 14) begin taken = 1'b1; c = code; end
            else err = 1'b1;
        end else if (tick && sr[1]) begin taken = 1'b1; c = 5'd5; end
        else if (ext && sr[2]) begin taken = 1'b1; c = 5'd8; end
        e_sr = sr; e_ds = ds;
        if (err) m_npc = pc;
        if (taken) begin
            m_epc  = pc - (ds ? 32'd4 : 32'd0) + ((c == 5'd12) ? 32'd4 : 32'd0);
            m_esr  = sr;
            e_sr   = (sr | 32'h1 | (ds ? 32'h20 : 32'h0)) & ~32'h1E;
            e_ds   = 1'b0;
            m_npc  = {27'd0, c} << 8;
            m_code = c;
            m_phys = 1'b1;
        end
        @(negedge clk);
        check("R2 saved pc", epc_o, m_epc);
        check("R3 saved status", esr_o, m_esr);
        check("R4 new status", sr_o, e_sr);
        check("R5 delay-slot flag", {31'd0, dslot_o}, {31'd0, e_ds});
        check("R6 vector", new_pc_o, m_npc);
        check("R6 code", {27'd0, exc_code_o}, {27'd0, m_code});
        check("R7 unhandled", {31'd0, unhandled_o}, {31'd0, err});
        check("R11 entry strobe", {31'd0, entry_valid_o}, {31'd0, taken});
        check("R11 flush", {31'd0, tlb_flush_o}, {31'd0, taken});
        check("R11 phys mode", {31'd0, phys_mode_o}, {31'd0, m_phys});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs zero during reset
        check("R1 reset npc", new_pc_o, 32'd0);
        check("R1 reset epc", epc_o, 32'd0);
        check("R1 reset flags", {28'd0, entry_valid_o, tlb_flush_o, phys_mode_o, unhandled_o}, 32'd0);
        rst_n = 1'b1;
        // idle cycle after reset, all zero (R1)
        step(32'd0, 32'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0);

        // R2 corner cases: plain, delay slot, syscall, syscall in delay slot
        step(32'h0000_2000, 32'h0000_0006, 1'b0, 1'b1, 5'd3,  1'b0, 1'b0);
        step(32'h0000_2000, 32'h0000_0006, 1'b1, 1'b1, 5'd3,  1'b0, 1'b0);
        step(32'h0000_2000, 32'h0000_0006, 1'b0, 1'b1, 5'd12, 1'b0, 1'b0);
        step(32'h0000_2000, 32'h0000_0006, 1'b1, 1'b1, 5'd12, 1'b0, 1'b0);

        // R6 / R7 sweep of every synchronous number, both delay-slot states
        for (int k = 0; k < 32; k++) begin
            for (int d = 0; d < 2; d++) begin
                step(32'h1000_0000 + 32'(k * 16), 32'hA5A5_001F ^ 32'(k), d[0], 1'b1,
                     5'(k), 1'b0, 1'b0);
                // R5 / R8 idle pass-through, saved values hold
                step(32'h0BAD_0000 + 32'(k), 32'h0000_00C0, ~d[0], 1'b0, 5'd0, 1'b0, 1'b0);
            end
        end

        // R8 / R9 / R10 interrupt matrix, with and without a sync request
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 16; m++) begin
                step(32'h0040_0000 + 32'(m * 4), {28'h0F0, 1'b0, m[1], m[0], 1'b0}, 1'b0,
                     s[0], 5'd2, m[2], m[3]);
            end
        end
        // R10: out-of-range sync code beats enabled interrupts
        step(32'h0000_7770, 32'h0000_0006, 1'b0, 1'b1, 5'd20, 1'b1, 1'b1);
        // R9: back-to-back tick entries
        step(32'h0000_0100, 32'h0000_0006, 1'b1, 1'b0, 5'd0, 1'b1, 1'b1);
        step(32'h0000_0200, 32'h0000_0006, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule